// File: doc/BRIEF.md
# Dual-Bank Instruction Memory with Paired-Word Fetch

This block is a read-only program store for a pipelined processor front end. Words are split across two banks by address parity: one bank holds the even word addresses and the other holds the odd ones. Both banks are read in the same cycle. The fetch port therefore returns the instruction at the requested program counter together with the word that follows it. A two-word instruction is available complete in one fetch, whatever the parity of its first word.

The fetch port has a stall input. While stall is high, the fetched pair and its lane-swap state are frozen, so the decoder keeps seeing the same instruction. A separate byte-addressed read port serves constant-data loads out of program space. It runs alongside the fetch port and ignores the stall. The program counter is also registered once, so that it arrives with the instruction it addressed. A word-wide preload port fills the banks for test, so no initialisation file is needed.

Top module: `banked_prog_mem`

## Requirements
- R1: While `rst` is high at a clock edge, `opc`, `pc_q` and `ro_data` are all zero after that edge.
- R2: For an even `pc` sampled at an edge with `stall` low, `opc[15:0]` equals memory word `pc[10:0]` and `opc[31:16]` equals word `pc[10:0]+1` after that edge.
- R3: For an odd `pc` sampled at an edge with `stall` low, `opc[15:0]` equals memory word `pc[10:0]` and `opc[31:16]` equals word `pc[10:0]+1` after that edge.
- R4: Word indices wrap modulo 2048 and `pc[15:11]` does not affect the fetch. At `pc[10:0]=2047`, the high half of `opc` is word 0.
- R5: While `stall` is high at an edge, `opc` keeps its previous value, including the lane order, whatever `pc` does. The first edge with `stall` low fetches the current `pc`.
- R6: `pc_q` equals the full 16-bit `pc` sampled at the previous edge, and it also updates during a stall.
- R7: `ro_data` is one byte of memory selected by the 12-bit `ro_addr`, available one edge later. Bits [11:2] select the row pair (word 2·row in the even bank, word 2·row+1 in the odd bank). Offset 0 gives the even-word low byte, 1 the even-word high byte, 2 the odd-word low byte and 3 the odd-word high byte.
- R8: The byte port is independent of `stall` and of fetches in the same cycle, and keeps updating while the fetch port is frozen.
- R9: With `ld_en` high at an edge, `ld_data` is stored at word `ld_addr`, where bit 0 selects the bank and bits [10:1] select the row. Later reads from either port return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes the fetch port |
| pc | input | 16 | Word address of the instruction to fetch |
| ro_addr | input | 12 | Byte address for constant reads |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 11 | Preload word address |
| ld_data | input | 16 | Preload word |
| opc | output | 32 | Word at pc (low half) and word at pc+1 (high half) |
| pc_q | output | 16 | pc delayed by one clock |
| ro_data | output | 8 | Byte read result |

## Verification
Every output of this block is due exactly one edge after its inputs are sampled: the fetched pair, the delayed counter and the read byte. Preload writes are visible from the next read onward. The bench changes its inputs one nanosecond after an edge and compares the outputs one nanosecond after the following edge, so each check falls in the single cycle where the result first appears. In the stall sequence the bench compares against the value captured before the stall, not against the new `pc`. The first edge after the stall is released is checked for the new fetch.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int unsigned DEF_PC_W   = 16;
  localparam int unsigned DEF_ROW_W  = 10;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned NUM_BANKS  = 2;

  localparam int unsigned BANK_EVEN = 0;
  localparam int unsigned BANK_ODD  = 1;

  typedef enum logic [1:0] {
    LANE_EVEN_LO = 2'd0,
    LANE_EVEN_HI = 2'd1,
    LANE_ODD_LO  = 2'd2,
    LANE_ODD_HI  = 2'd3
  } byte_lane_e;
endpackage

// File: rtl/bpm_addr_gen.sv
module bpm_addr_gen #(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned BYTE_ADDR_W = ROW_W + 2
) (
  input  logic [ROW_W:0]       fetch_word,
  input  logic [BYTE_ADDR_W-1:0] rd_byte,
  output logic [ROW_W-1:0]     row_even,
  output logic [ROW_W-1:0]     row_odd,
  output logic [ROW_W-1:0]     row_byte
);
  logic [ROW_W-1:0] base_row;

  always_comb begin
    base_row = fetch_word[ROW_W:1];
    row_odd  = base_row;
    // an odd start needs the next even word, one row further on
    row_even = base_row + ROW_W'(fetch_word[0]);
    row_byte = rd_byte[BYTE_ADDR_W-1:2];
  end
endmodule

// File: rtl/bpm_bank.sv
module bpm_bank #(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fa_en,
  input  logic [ROW_W-1:0]  fa_row,
  output logic [WORD_W-1:0] fa_q,
  input  logic [ROW_W-1:0]  rb_row,
  output logic [WORD_W-1:0] rb_q,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_row] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) fa_q <= '0;
    else if (fa_en) fa_q <= store[fa_row];
  end

  always_ff @(posedge clk) begin
    if (rst) rb_q <= '0;
    else rb_q <= store[rb_row];
  end
endmodule

// File: rtl/bpm_out_mux.sv
module bpm_out_mux
  import bpm_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stall,
  input  logic                fetch_par,
  input  logic [1:0]          lane_in,
  input  logic [WORD_W-1:0]   fa_even,
  input  logic [WORD_W-1:0]   fa_odd,
  input  logic [WORD_W-1:0]   rb_even,
  input  logic [WORD_W-1:0]   rb_odd,
  output logic [2*WORD_W-1:0] pair_out,
  output logic [WORD_W/2-1:0] byte_out
);
  localparam int unsigned BYTE_W = WORD_W / 2;

  logic       par_q;
  byte_lane_e lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= 1'b0;
      lane_q <= LANE_EVEN_LO;
    end else begin
      if (!stall) par_q <= fetch_par;
      lane_q <= byte_lane_e'(lane_in);
    end
  end

  always_comb begin
    if (par_q) pair_out = {fa_even, fa_odd};
    else       pair_out = {fa_odd, fa_even};
  end

  always_comb begin
    unique case (lane_q)
      LANE_EVEN_LO: byte_out = rb_even[BYTE_W-1:0];
      LANE_EVEN_HI: byte_out = rb_even[WORD_W-1:BYTE_W];
      LANE_ODD_LO:  byte_out = rb_odd[BYTE_W-1:0];
      default:      byte_out = rb_odd[WORD_W-1:BYTE_W];
    endcase
  end

  AST_PAR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(stall) |-> $stable(par_q)); // R5

  AST_LANE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (lane_q == $past(lane_in))); // R7
endmodule

// File: rtl/banked_prog_mem.sv
module banked_prog_mem
  import bpm_pkg::*;
#(
  parameter int unsigned PC_W   = DEF_PC_W,
  parameter int unsigned ROW_W  = DEF_ROW_W,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned BYTE_ADDR_W = ROW_W + 2,
  localparam int unsigned LD_W        = ROW_W + 1,
  localparam int unsigned OPC_W       = 2 * WORD_W,
  localparam int unsigned BYTE_W      = WORD_W / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stall,
  input  logic [PC_W-1:0]        pc,
  input  logic [BYTE_ADDR_W-1:0] ro_addr,
  input  logic                   ld_en,
  input  logic [LD_W-1:0]        ld_addr,
  input  logic [WORD_W-1:0]      ld_data,
  output logic [OPC_W-1:0]       opc,
  output logic [PC_W-1:0]        pc_q,
  output logic [BYTE_W-1:0]      ro_data
);
  logic [ROW_W-1:0]  row_fa [NUM_BANKS];
  logic [ROW_W-1:0]  row_rb;
  logic [WORD_W-1:0] fa_q   [NUM_BANKS];
  logic [WORD_W-1:0] rb_q   [NUM_BANKS];

  bpm_addr_gen #(.ROW_W(ROW_W), .BYTE_ADDR_W(BYTE_ADDR_W)) u_addr (
    .fetch_word (pc[ROW_W:0]),
    .rd_byte    (ro_addr),
    .row_even   (row_fa[BANK_EVEN]),
    .row_odd    (row_fa[BANK_ODD]),
    .row_byte   (row_rb)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = ld_en && (ld_addr[0] == 1'(b));

    bpm_bank #(.ROW_W(ROW_W), .WORD_W(WORD_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .fa_en   (!stall),
      .fa_row  (row_fa[b]),
      .fa_q    (fa_q[b]),
      .rb_row  (row_rb),
      .rb_q    (rb_q[b]),
      .wr_en   (bank_wr),
      .wr_row  (ld_addr[LD_W-1:1]),
      .wr_data (ld_data)
    );
  end

  bpm_out_mux #(.WORD_W(WORD_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .fetch_par (pc[0]),
    .lane_in   (ro_addr[1:0]),
    .fa_even   (fa_q[BANK_EVEN]),
    .fa_odd    (fa_q[BANK_ODD]),
    .rb_even   (rb_q[BANK_EVEN]),
    .rb_odd    (rb_q[BANK_ODD]),
    .pair_out  (opc),
    .byte_out  (ro_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc;
  end

  AST_PCQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (pc_q == $past(pc))); // R6

  AST_OPC_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(stall) |-> $stable(opc)); // R5
endmodule

// File: tb/sim_banked_prog_mem.sv
`timescale 1ns/1ps
module sim_banked_prog_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [15:0] pc = '0;
  logic [11:0] ro_addr = '0;
  logic        ld_en = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [31:0] opc;
  logic [15:0] pc_q;
  logic [7:0]  ro_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] ref_mem [2048];

  always #2.5 clk = ~clk;

  banked_prog_mem u0 (
    .clk(clk), .rst(rst), .stall(stall), .pc(pc), .ro_addr(ro_addr),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .opc(opc), .pc_q(pc_q), .ro_data(ro_data)
  );

  // pc in [27:12], byte address in [11:0]
  localparam int NVEC = 10;
  localparam logic [27:0] VEC [NVEC] = '{
    {16'h0000, 12'h000}, // R2 even, R7 offset 0
    {16'h0001, 12'h001}, // R3 odd, R7 offset 1
    {16'h0002, 12'h002}, // R2, R7 offset 2
    {16'h0003, 12'h003}, // R3, R7 offset 3
    {16'h07FE, 12'hFFC}, // R2 top even
    {16'h07FF, 12'hFFF}, // R4 wrap
    {16'hF805, 12'hABD}, // R4 upper bits ignored
    {16'h0155, 12'h556},
    {16'h02AA, 12'h3A9},
    {16'h1400, 12'h7FE}
  };

  function automatic logic [15:0] pattern(int i);
    return 16'(i * 40503) ^ 16'h3C5A;
  endfunction

  function automatic logic [7:0] ref_byte(logic [11:0] a);
    logic [15:0] w;
    w = ref_mem[a[11:1]];
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [31:0] ref_pair(logic [15:0] p);
    logic [10:0] lo;
    lo = p[10:0];
    return {ref_mem[11'(lo + 11'd1)], ref_mem[lo]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    tick(); tick(); tick();
    check("R1 opc", opc, 32'h0);
    check("R1 pc_q", {16'h0, pc_q}, 32'h0);
    check("R1 ro_data", {24'h0, ro_data}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < 2048; i++) begin
      ref_mem[i] = pattern(i);
      ld_en = 1'b1; ld_addr = 11'(i); ld_data = pattern(i);
      tick();
    end
    ld_en = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      pc = VEC[v][27:12];
      ro_addr = VEC[v][11:0];
      tick();
      check(pc[0] ? "R3 R4 opc" : "R2 R4 opc", opc, ref_pair(pc));
      check("R6 pc_q", {16'h0, pc_q}, {16'h0, pc});
      check("R7 ro_data", {24'h0, ro_data}, {24'h0, ref_byte(ro_addr)});
    end

    // stall sequence: odd start, then two frozen cycles
    pc = 16'h0101; ro_addr = 12'h010;
    tick();
    held = opc;
    check("R3 pre-stall", opc, ref_pair(16'h0101));
    stall = 1'b1; pc = 16'h0200; ro_addr = 12'h203;
    tick();
    check("R5 held", opc, held);
    check("R6 during stall", {16'h0, pc_q}, 32'h0200);
    check("R8 byte during stall", {24'h0, ro_data}, {24'h0, ref_byte(12'h203)});
    pc = 16'h0300; ro_addr = 12'h402;
    tick();
    check("R5 held 2", opc, held);
    check("R8 byte during stall 2", {24'h0, ro_data}, {24'h0, ref_byte(12'h402)});
    stall = 1'b0;
    tick();
    check("R5 release", opc, ref_pair(16'h0300));

    // preload overwrite
    ld_en = 1'b1; ld_addr = 11'd5; ld_data = 16'hBEEF;
    tick();
    ld_en = 1'b0;
    ref_mem[5] = 16'hBEEF;
    pc = 16'h0004; ro_addr = 12'h00B;
    tick();
    check("R9 fetch", opc, ref_pair(16'h0004));
    check("R9 byte", {24'h0, ro_data}, 32'h0000_00BE);

    // reset again mid-run
    rst = 1'b1;
    tick();
    check("R1 re-reset opc", opc, 32'h0);
    check("R1 re-reset byte", {24'h0, ro_data}, 32'h0);
    rst = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule